// File: doc/BRIEF.md
# Bus Word Data Type Classifier

This block sits beside a memory data path and attaches a guessed data type to every 32-bit word that crosses it, so that a downstream compressor can pick an encoding policy per word. The guess uses only the word's bit pattern and whether the transfer belongs to an instruction fetch. Five tags exist: code, integer, text, double and pointer. The tests are applied in a fixed priority. Instruction fetch comes first, then the sign-extended integer test, then the ASCII text test, then a test of two adjacent words for a small floating-point exponent. Any word that fails all of these is a pointer.

The double test needs a pair of adjacent words, so each word is held until its successor arrives or a flush is requested, and only then is it passed on with its final tag. Words pass through unchanged and in order. Both stream edges use valid/ready. A word moves when valid and ready are both high at a rising clock edge. A presented output word, and its tag, stay stable while the downstream holds ready low. The block takes a new word whenever nothing is pending, or whenever the output register is empty or being drained in the same cycle. The flush input is a plain level. While it is high and no input word is taken, the pending word is released as soon as the output register can accept it.

Top module: `bus_word_classifier`

## Requirements
- R1: A word taken with the fetch flag set gets tag 0 (code), whatever its value.
- R2: A non-fetch word whose bits [31:24] are 8'h00 or 8'hFF gets tag 1 (integer).
- R3: A non-fetch, non-integer word in which bit 7 of each byte is 0 and bit 6 of at least one byte is 1 gets tag 2 (text).
- R4: Call a word a candidate when it is not fetch, not integer and not text. If a candidate with bits [30:27] equal to 4'b0111 or 4'b1000 (bit 31 ignored) is followed directly by another candidate, both words get tag 3 (double).
- R5: A candidate that does not form a double pair under R4 gets tag 4 (pointer). This includes a small-exponent candidate followed by a non-candidate, or one released by flush.
- R6: Pairing is greedy and never overlaps. The first word after reset or after a flush drain can open a pair. A word that closed a pair cannot open a new pair, so three small-exponent candidates in a row give double, double, pointer.
- R7: A word is output only after the next word is taken or a flush releases it. A word held as the second half of a pair is released by flush with tag 3.
- R8: Words leave in arrival order with their value unchanged. While out_valid is high and out_ready low, out_word and out_tag stay stable. A taken word is never dropped.
- R9: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is presented |
| in_ready | output | 1 | Block can take the presented word |
| in_word | input | 32 | Bus data word |
| in_fetch | input | 1 | Word belongs to an instruction fetch |
| flush | input | 1 | Release the pending word without a partner |
| out_valid | output | 1 | Output word and tag are presented |
| out_ready | input | 1 | Downstream takes the output word |
| out_word | output | 32 | Word passed through unchanged |
| out_tag | output | 3 | Type tag: 0 code, 1 integer, 2 text, 3 double, 4 pointer |

## Verification
The hardest case to reach from the ports is a word held as the second half of a double while the next small-exponent candidate arrives under back-pressure. The held word must leave as double, and the newcomer must not be paired with it. The same held word may instead meet a flush. The stimulus builds runs of small-exponent candidates of odd and even length, ending some runs with a flush and others with a non-candidate. A long mixed segment then interleaves all word kinds while the downstream drops ready for about 40% of cycles. The bench recomputes every tag with a greedy scan over each flushed segment.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  typedef enum logic [2:0] {
    TAG_CODE   = 3'd0,
    TAG_INT    = 3'd1,
    TAG_TEXT   = 3'd2,
    TAG_DOUBLE = 3'd3,
    TAG_PTR    = 3'd4
  } bwc_tag_e;

  // Single-word verdict before the pair test is resolved
  typedef struct packed {
    bwc_tag_e base;       // tag the word gets when unpaired
    logic     cand;       // neither fetch, integer nor text
    logic     small_exp;  // exponent field in the small window
  } bwc_class_t;
endpackage

// File: rtl/bwc_inspect.sv
module bwc_inspect
  import bwc_pkg::*;
#(
  parameter int          WORD_W    = 32,
  parameter logic [3:0]  EXP_BELOW = 4'b0111,
  parameter logic [3:0]  EXP_ABOVE = 4'b1000
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              fetch_i,
  output bwc_class_t        cls_o
);
  localparam int NBYTES = WORD_W / 8;
  localparam int TOP    = WORD_W - 1;

  logic [NBYTES-1:0] hi_clear;
  logic [NBYTES-1:0] b6_set;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign hi_clear[b] = ~word_i[8*b+7];
    assign b6_set[b]   =  word_i[8*b+6];
  end

  logic       sign_ext;
  logic       ascii;
  logic [3:0] exp_field;

  assign sign_ext  = (word_i[TOP -: 8] == 8'h00) || (word_i[TOP -: 8] == 8'hFF);
  assign ascii     = (&hi_clear) && (|b6_set);
  assign exp_field = word_i[TOP-1 -: 4];

  always_comb begin
    cls_o.base      = TAG_PTR;
    cls_o.cand      = 1'b0;
    cls_o.small_exp = (exp_field == EXP_BELOW) || (exp_field == EXP_ABOVE);
    if (fetch_i)       cls_o.base = TAG_CODE;
    else if (sign_ext) cls_o.base = TAG_INT;
    else if (ascii)    cls_o.base = TAG_TEXT;
    else               cls_o.cand = 1'b1;
  end
endmodule

// File: rtl/bwc_pend_stage.sv
module bwc_pend_stage
  import bwc_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              release_i,
  input  logic [WORD_W-1:0] word_i,
  input  bwc_class_t        cls_i,
  input  logic              paired_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] word_o,
  output bwc_class_t        cls_o,
  output logic              paired_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      paired_o <= 1'b0;
      word_o   <= '0;
      cls_o    <= '{base: TAG_PTR, cand: 1'b0, small_exp: 1'b0};
    end else if (load_i) begin
      valid_o  <= 1'b1;
      paired_o <= paired_i;
      word_o   <= word_i;
      cls_o    <= cls_i;
    end else if (release_i) begin
      valid_o  <= 1'b0;
      paired_o <= 1'b0;
    end
  end

  // A word closing a pair must itself have been a candidate
  assert_paired_is_cand_R4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && paired_o |-> cls_o.cand);

  // Pending storage is only emptied by flush when it held something
  assert_release_needs_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |-> valid_o);
endmodule

// File: rtl/bwc_out_stage.sv
module bwc_out_stage
  import bwc_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  input  bwc_tag_e          tag_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] word_o,
  output bwc_tag_e          tag_o,
  output logic              free_o
);
  assign free_o = !valid_o || ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      word_o  <= '0;
      tag_o   <= TAG_PTR;
    end else if (load_i) begin
      valid_o <= 1'b1;
      word_o  <= word_i;
      tag_o   <= tag_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o && $stable(word_o) && $stable(tag_o));

  assert_no_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> free_o);
endmodule

// File: rtl/bus_word_classifier.sv
module bus_word_classifier
  import bwc_pkg::*;
#(
  parameter int         WORD_W    = 32,
  parameter logic [3:0] EXP_BELOW = 4'b0111,
  parameter logic [3:0] EXP_ABOVE = 4'b1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_fetch,
  input  logic              flush,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic [2:0]        out_tag
);
  bwc_class_t        new_cls;
  logic              pend_v;
  logic [WORD_W-1:0] pend_word;
  bwc_class_t        pend_cls;
  logic              pend_paired;
  logic              out_free;
  logic              in_fire;
  logic              pair_now;
  logic              rel_flush;
  logic              out_load;
  bwc_tag_e          rel_tag;
  bwc_tag_e          out_tag_q;

  bwc_inspect #(
    .WORD_W(WORD_W), .EXP_BELOW(EXP_BELOW), .EXP_ABOVE(EXP_ABOVE)
  ) u_inspect (
    .word_i (in_word),
    .fetch_i(in_fetch),
    .cls_o  (new_cls)
  );

  assign in_ready  = !pend_v || out_free;
  assign in_fire   = in_valid && in_ready;
  // Pending word opens a pair only if it did not already close one
  assign pair_now  = pend_v && !pend_paired && pend_cls.cand && pend_cls.small_exp
                     && new_cls.cand;
  assign rel_flush = flush && pend_v && !in_fire && out_free;
  assign out_load  = (in_fire && pend_v) || rel_flush;
  assign rel_tag   = (pend_paired || (in_fire && pair_now)) ? TAG_DOUBLE : pend_cls.base;

  bwc_pend_stage #(.WORD_W(WORD_W)) u_pend (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (in_fire),
    .release_i(rel_flush),
    .word_i   (in_word),
    .cls_i    (new_cls),
    .paired_i (pair_now),
    .valid_o  (pend_v),
    .word_o   (pend_word),
    .cls_o    (pend_cls),
    .paired_o (pend_paired)
  );

  bwc_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (out_load),
    .word_i (pend_word),
    .tag_i  (rel_tag),
    .ready_i(out_ready),
    .valid_o(out_valid),
    .word_o (out_word),
    .tag_o  (out_tag_q),
    .free_o (out_free)
  );

  assign out_tag = out_tag_q;

  assert_fetch_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && in_fetch |=> pend_v && pend_cls.base == TAG_CODE);

  assert_pair_both_double_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && pair_now |=> out_valid && out_tag == 3'd3 && pend_paired);

  assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && pend_v && pend_paired |=> !pend_paired);

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rel_flush |=> !pend_v && out_valid);

  assert_tag_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_tag <= 3'd4);
endmodule

// File: tb/test_bus_word_classifier.sv
module test_bus_word_classifier;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_fetch, flush;
  logic [31:0] in_word;
  logic        out_valid, out_ready;
  logic [31:0] out_word;
  logic [2:0]  out_tag;

  always #2 clk = ~clk;  // 250 MHz

  bus_word_classifier i_bus_word_classifier (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_fetch(in_fetch), .flush(flush),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word), .out_tag(out_tag)
  );

  int          n_checks = 0;
  int          n_fail   = 0;
  int          stall_pct = 0;
  logic [31:0] seg_w[$];
  bit          seg_f[$];
  logic [31:0] got_w[$];
  int          got_t[$];
  bit          stall_seen = 0;
  logic [31:0] prev_word;
  logic [2:0]  prev_tag;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int base_tag(logic [31:0] w, bit f);
    if (f) return 0;
    if (w[31:24] == 8'h00 || w[31:24] == 8'hFF) return 1;
    if ((w & 32'h80808080) == 0 && (w & 32'h40404040) != 0) return 2;
    return 4;
  endfunction

  function automatic bit small_exp(logic [31:0] w);
    return (w[30:27] == 4'b0111) || (w[30:27] == 4'b1000);
  endfunction

  function automatic string req_of(int t);
    case (t)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      default: return "R5";
    endcase
  endfunction

  // Receiver: random back-pressure, protocol check (R8), collection
  initial begin
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      out_ready = ($urandom_range(99) >= stall_pct);
      #1;
      if (stall_seen) begin
        check(out_valid == 1'b1, "R8", "valid dropped under stall", out_valid, 1);
        check(out_word == prev_word && out_tag == prev_tag, "R8", "word changed under stall",
              out_word, prev_word);
      end
      stall_seen = rst_n && out_valid && !out_ready;
      prev_word  = out_word;
      prev_tag   = out_tag;
      if (rst_n && out_valid && out_ready) begin
        got_w.push_back(out_word);
        got_t.push_back(int'(out_tag));
      end
    end
  end

  task automatic send(logic [31:0] w, bit f);
    seg_w.push_back(w);
    seg_f.push_back(f);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    in_fetch = f;
    forever begin
      #1;
      if (in_ready) break;
      @(negedge clk);
    end
    @(posedge clk);
  endtask

  // Flush, drain, then compare against a greedy scan of the segment
  task automatic end_segment(string ctx);
    int n;
    int exp_t[$];
    @(negedge clk);
    in_valid = 1'b0;
    flush    = 1'b1;
    while (got_w.size() < seg_w.size()) @(negedge clk);
    flush = 1'b0;
    n = seg_w.size();
    for (int i = 0; i < n; i++) exp_t.push_back(base_tag(seg_w[i], seg_f[i]));
    for (int i = 0; i < n; i++) begin
      if (exp_t[i] == 4 && small_exp(seg_w[i]) && i + 1 < n && exp_t[i+1] == 4) begin
        exp_t[i]   = 3;
        exp_t[i+1] = 3;
        i++;
      end
    end
    check(got_w.size() == n, "R8", {ctx, " word count"}, got_w.size(), n);
    for (int i = 0; i < n && i < got_w.size(); i++) begin
      check(got_w[i] == seg_w[i], "R8", {ctx, " word order"}, got_w[i], seg_w[i]);
      check(got_t[i] == exp_t[i], req_of(exp_t[i]), {ctx, " tag"}, got_t[i], exp_t[i]);
    end
    seg_w.delete(); seg_f.delete(); got_w.delete(); got_t.delete();
  endtask

  function automatic logic [31:0] gen_word(int kind);
    logic [31:0] w = $urandom;
    case (kind)
      1: w[31:24] = ($urandom_range(1) == 1) ? 8'hFF : 8'h00;
      2: for (int b = 0; b < 4; b++) w[8*b +: 8] = 8'($urandom_range(8'h40, 8'h7E));
      3: begin
        w[30:27] = ($urandom_range(1) == 1) ? 4'b0111 : 4'b1000;
        w[23]    = 1'b1;
      end
      default: begin
        w[31:24] = 8'($urandom_range(1, 254));
        w[23]    = 1'b1;
      end
    endcase
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R7 watchdog: actual hung expected drained");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; in_fetch = 1'b0; flush = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9: idle after reset
    check(out_valid == 1'b0, "R9", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R9", "in_ready after reset", in_ready, 1);

    // R7: a lone word waits for its successor
    send(32'h12345678, 1'b0);
    @(negedge clk); in_valid = 1'b0;
    repeat (5) @(negedge clk);
    #2;
    check(got_w.size() == 0 && out_valid == 1'b0, "R7", "early release", got_w.size(), 0);
    send(32'h80001000, 1'b0);
    @(negedge clk); in_valid = 1'b0;
    repeat (4) @(negedge clk);
    #2;
    check(got_w.size() == 1, "R7", "release on successor", got_w.size(), 1);
    end_segment("R7 delay");

    // R1, R2, R3, R5: single-word tags, fetch overrides an integer pattern
    send(32'h00000005, 1'b1);
    send(32'h00000005, 1'b0);
    send(32'hFFFFFFF0, 1'b0);
    send(32'h41424344, 1'b0);
    send(32'h00414243, 1'b0);
    send(32'h80001000, 1'b0);
    send(32'h3FF00000, 1'b1);
    end_segment("single");

    // R4, R5: pair, then small exponent followed by non-candidates
    send(32'h3FF00000, 1'b0);
    send(32'h8ABCDEF0, 1'b0);
    send(32'h40800000, 1'b0);
    send(32'h00000001, 1'b0);
    send(32'hC0800000, 1'b0);
    send(32'h12345678, 1'b1);
    send(32'hBF800001, 1'b0);
    end_segment("R4 pair");

    // R6: odd run ends pointer; even run ends double held across flush (R7)
    send(32'h3F800000, 1'b0);
    send(32'h40800000, 1'b0);
    send(32'hBF900000, 1'b0);
    end_segment("R6 odd run");
    stall_pct = 50;
    send(32'h3F800000, 1'b0);
    send(32'h40800000, 1'b0);
    send(32'hBF900000, 1'b0);
    send(32'hC0A00000, 1'b0);
    end_segment("R6 even run");

    // Long mixed stream under back-pressure
    stall_pct = 40;
    for (int k = 0; k < 400; k++) begin
      int kind = $urandom_range(5);
      send(gen_word(kind), kind == 0);
      if (k % 97 == 96) end_segment("mixed");
    end
    end_segment("mixed tail");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule